// File: doc/BRIEF.md
# Interrupt Flag Control Unit

This block sits beside the retirement stage of a processor core and owns two architectural bits: the interrupt-enable flag and the virtual interrupt-enable flag. Each retired instruction comes with a strobe, an opcode class and a lock-prefix bit. The block also receives the current mode and privilege state. An enable instruction either sets the interrupt-enable flag, sets the virtual flag, or raises a fault. Which one happens depends on a decision table over protection enable, the virtual-8086 bit, the current and I/O privilege levels, the virtual-interrupt-pending bit and two mode-extension enables. A disable instruction clears the interrupt-enable flag.

The block also gates the core's interrupt lines. An enable that turns the flag from 0 to 1 opens a one-instruction window during which maskable interrupts and NMI are held off. A two-state machine tracks this window. In `GATE_OPEN`, requests are accepted normally. `ARM` (retirement of an enable that turns the flag from 0 to 1 without a fault) moves the machine to `GATE_HOLD`. In `GATE_HOLD`, both accept outputs are forced low. `RELEASE` (the next retirement of any instruction) returns the machine to `GATE_OPEN`. Faults are reported in the retire cycle and are never masked by the window.

Top module: `intr_flag_ctl`

## Requirements
- R1: After reset, `if_o` and `vif_o` are 0, `fault_o` is 0 and neither accept output is asserted.
- R2: With `pe_i`=0, an enable (`op_i`=2'b01) without lock sets `if_o` and reports no fault.
- R3: With `pe_i`=1, an enable without lock sets `if_o` when `iopl_i` is at least the effective privilege level. The effective level is `cpl_i`, or 3 when `vm_i`=1.
- R4: With `pe_i`=1 and `iopl_i` below the effective level, an enable sets `vif_o` and leaves `if_o` unchanged when `vip_i`=0 and an extension mode is active. The protected extension is active when `vm_i`=0, `cpl_i`=3 and `pvi_en_i`=1. The virtual-8086 extension is active when `vm_i`=1 and `vme_en_i`=1.
- R5: With `pe_i`=1 and `iopl_i` below the effective level, an enable reports a general-protection fault (`fault_o`=2'b01) when `vip_i`=1 or no extension mode is active, and no flag changes.
- R6: An enable or disable with `lock_i`=1 reports an invalid-opcode fault (`fault_o`=2'b10) in every mode, and no flag changes.
- R7: A disable (`op_i`=2'b10) without lock clears `if_o` in every mode, reports no fault and leaves `vif_o` unchanged.
- R8: After an enable that moves `if_o` from 0 to 1, `intr_ack_o` stays 0 until one more instruction has retired.
- R9: An enable retired while `if_o` is already 1 opens no shadow window, so a pending request is accepted right after it.
- R10: A disable retired right after an enable leaves `intr_ack_o` at 0 before and after it.
- R11: `intr_ack_o` is 1 exactly when `if_o` is 1, no shadow is active and `intr_req_i` is 1.
- R12: `nmi_ack_o` follows `nmi_req_i` except during the shadow window. Faults are still reported while the window is active.
- R13: `fault_o` is nonzero only in a cycle with `retire_i`=1. A cycle without retirement, or the retirement of any other opcode class (2'b00), changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One instruction retires this cycle |
| op_i | input | 2 | Opcode class: 00 other, 01 enable, 10 disable |
| lock_i | input | 1 | Lock prefix present on the retiring instruction |
| pe_i | input | 1 | Protection enabled |
| vm_i | input | 1 | Virtual-8086 mode bit |
| cpl_i | input | PL_W | Current privilege level |
| iopl_i | input | PL_W | I/O privilege level |
| vip_i | input | 1 | Virtual interrupt pending |
| pvi_en_i | input | 1 | Protected-mode virtual interrupt extension enable |
| vme_en_i | input | 1 | Virtual-8086 extension enable |
| intr_req_i | input | 1 | Maskable interrupt pending |
| nmi_req_i | input | 1 | Non-maskable interrupt pending |
| if_o | output | 1 | Interrupt-enable flag |
| vif_o | output | 1 | Virtual interrupt-enable flag |
| fault_o | output | 2 | 00 none, 01 general protection (error code 0), 10 invalid opcode |
| intr_ack_o | output | 1 | Maskable interrupt accepted |
| nmi_ack_o | output | 1 | NMI accepted |

## Verification
The shadow machine holds hidden state. If it is stuck in `GATE_HOLD`, every later request is refused on both accept outputs. If it fails to arm, `intr_ack_o` rises in the first cycle after the enable retires. Either error shows on the port one cycle after the retirement that should have changed it. A wrong decision-table outcome shows in the same cycle as the retire strobe on `fault_o`, and on the next cycle as a flag that moved or failed to move.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
    typedef enum logic [1:0] {
        OPC_OTHER = 2'b00,
        OPC_SET   = 2'b01,
        OPC_CLR   = 2'b10,
        OPC_RSV   = 2'b11
    } opc_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_GP   = 2'b01,
        FLT_UD   = 2'b10,
        FLT_RSV  = 2'b11
    } flt_e;

    typedef struct packed {
        logic set_if;
        logic clr_if;
        logic set_vif;
        flt_e fault;
    } act_t;
endpackage

// File: rtl/ifc_decide.sv
module ifc_decide
    import ifc_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  logic [1:0]      op_i,
    input  logic            lock_i,
    input  logic            pe_i,
    input  logic            vm_i,
    input  logic [PL_W-1:0] cpl_i,
    input  logic [PL_W-1:0] iopl_i,
    input  logic            vip_i,
    input  logic            pvi_en_i,
    input  logic            vme_en_i,
    output act_t            act_o
);
    localparam logic [PL_W-1:0] PL_USER = '1;

    logic [PL_W-1:0] eff_cpl;
    logic            ext_prot;
    logic            ext_v86;

    assign eff_cpl  = vm_i ? PL_USER : cpl_i;
    assign ext_prot = pe_i & ~vm_i & (cpl_i == PL_USER) & pvi_en_i;
    assign ext_v86  = pe_i & vm_i & vme_en_i;

    always_comb begin
        act_o = '{set_if: 1'b0, clr_if: 1'b0, set_vif: 1'b0, fault: FLT_NONE};
        unique case (opc_e'(op_i))
            OPC_SET: begin
                if (lock_i)                  act_o.fault  = FLT_UD;
                else if (!pe_i)              act_o.set_if = 1'b1;
                else if (iopl_i >= eff_cpl)  act_o.set_if = 1'b1;
                else if ((ext_prot || ext_v86) && !vip_i)
                                             act_o.set_vif = 1'b1;
                else                         act_o.fault  = FLT_GP;
            end
            OPC_CLR: begin
                if (lock_i) act_o.fault  = FLT_UD;
                else        act_o.clr_if = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ifc_shadow_fsm.sv
module ifc_shadow_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic retire_i,
    output logic shadow_o
);
    typedef enum logic {
        GATE_OPEN = 1'b0,
        GATE_HOLD = 1'b1
    } gate_e;

    gate_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OPEN: if (arm_i)    state_d = GATE_HOLD;           // ARM
            GATE_HOLD: if (retire_i) state_d = arm_i ? GATE_HOLD    // re-ARM
                                                     : GATE_OPEN;   // RELEASE
            default:                 state_d = GATE_OPEN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            GATE_HOLD: shadow_o = 1'b1;
            default:   shadow_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/intr_flag_ctl.sv
module intr_flag_ctl
    import ifc_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            retire_i,
    input  logic [1:0]      op_i,
    input  logic            lock_i,
    input  logic            pe_i,
    input  logic            vm_i,
    input  logic [PL_W-1:0] cpl_i,
    input  logic [PL_W-1:0] iopl_i,
    input  logic            vip_i,
    input  logic            pvi_en_i,
    input  logic            vme_en_i,
    input  logic            intr_req_i,
    input  logic            nmi_req_i,
    output logic            if_o,
    output logic            vif_o,
    output logic [1:0]      fault_o,
    output logic            intr_ack_o,
    output logic            nmi_ack_o
);
    act_t act;
    logic if_q, vif_q, shadow, arm, commit;

    ifc_decide #(.PL_W(PL_W)) u_decide (
        .op_i    (op_i),
        .lock_i  (lock_i),
        .pe_i    (pe_i),
        .vm_i    (vm_i),
        .cpl_i   (cpl_i),
        .iopl_i  (iopl_i),
        .vip_i   (vip_i),
        .pvi_en_i(pvi_en_i),
        .vme_en_i(vme_en_i),
        .act_o   (act)
    );

    assign commit = retire_i && (act.fault == FLT_NONE);
    assign arm    = commit && act.set_if && !if_q;

    ifc_shadow_fsm u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (arm),
        .retire_i(retire_i),
        .shadow_o(shadow)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if_q  <= 1'b0;
            vif_q <= 1'b0;
        end else if (commit) begin
            if (act.set_if)       if_q  <= 1'b1;
            else if (act.clr_if)  if_q  <= 1'b0;
            if (act.set_vif)      vif_q <= 1'b1;
        end
    end

    assign if_o       = if_q;
    assign vif_o      = vif_q;
    assign fault_o    = retire_i ? act.fault : FLT_NONE;
    assign intr_ack_o = if_q && !shadow && intr_req_i;
    assign nmi_ack_o  = nmi_req_i && !shadow;
endmodule

// File: rtl/intr_flag_chk.sv
module intr_flag_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       retire_i,
    input logic [1:0] op_i,
    input logic       lock_i,
    input logic       if_o,
    input logic       vif_o,
    input logic [1:0] fault_o,
    input logic       intr_ack_o
);
    p_fault_only_retire_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !retire_i |-> fault_o == 2'b00);

    p_fault_keeps_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && fault_o != 2'b00) |=> ($stable(if_o) && $stable(vif_o)));

    p_lock_faults_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && lock_i && (op_i == 2'b01 || op_i == 2'b10)) |-> fault_o == 2'b10);

    p_accept_needs_if_r11: assert property (@(posedge clk) disable iff (!rst_n)
        intr_ack_o |-> if_o);

    p_shadow_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && op_i == 2'b01 && fault_o == 2'b00 && !if_o) |=> !intr_ack_o);

    p_vif_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vif_o |=> vif_o);

    p_clear_drops_if_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && op_i == 2'b10 && !lock_i) |=> !if_o);
endmodule

bind intr_flag_ctl intr_flag_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .retire_i  (retire_i),
    .op_i      (op_i),
    .lock_i    (lock_i),
    .if_o      (if_o),
    .vif_o     (vif_o),
    .fault_o   (fault_o),
    .intr_ack_o(intr_ack_o)
);

// File: tb/intr_flag_ctl_tb.sv
`timescale 1ns/1ps
module intr_flag_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       retire = 1'b0;
    logic [1:0] op = 2'b00;
    logic       lock = 1'b0, pe = 1'b0, vm = 1'b0, vip = 1'b0, pvi = 1'b0, vme = 1'b0;
    logic [1:0] cpl = 2'd0, iopl = 2'd0;
    logic       ireq = 1'b0, nreq = 1'b0;
    logic       if_o, vif_o, iack, nack;
    logic [1:0] fault;
    logic [1:0] last_fault;
    int n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    intr_flag_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .retire_i(retire), .op_i(op), .lock_i(lock),
        .pe_i(pe), .vm_i(vm), .cpl_i(cpl), .iopl_i(iopl), .vip_i(vip),
        .pvi_en_i(pvi), .vme_en_i(vme), .intr_req_i(ireq), .nmi_req_i(nreq),
        .if_o(if_o), .vif_o(vif_o), .fault_o(fault), .intr_ack_o(iack), .nmi_ack_o(nack)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; retire = 1'b0; op = 2'b00; lock = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    // drive one retirement at a negedge, sample fault mid-cycle, flags after the edge
    task automatic do_retire(input logic [1:0] o);
        @(negedge clk);
        retire = 1'b1; op = o;
        #1 last_fault = fault;
        @(negedge clk);
        retire = 1'b0; op = 2'b00;
        #1;
    endtask

    task automatic set_mode(input logic p, input logic v, input logic [1:0] c,
                            input logic [1:0] io, input logic vp, input logic pv,
                            input logic ve, input logic lk);
        pe = p; vm = v; cpl = c; iopl = io; vip = vp; pvi = pv; vme = ve; lock = lk;
    endtask

    initial begin
        #(200000 * 4);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        ireq = 1'b1; nreq = 1'b1;
        do_reset();
        // R1 reset state
        chk("R1 if", if_o, 0); chk("R1 vif", vif_o, 0);
        chk("R1 fault", fault, 0); chk("R1 intr_ack", iack, 0);

        // Exhaustive sweep of the enable instruction
        for (int c = 0; c < 2048; c++) begin
            logic lk, p, v, vp, pv, ve, prior;
            logic [1:0] cp, io, ecpl, exp_f;
            logic exp_if, exp_vif, ext, shad;
            string tag;
            lk = c[0]; p = c[1]; v = c[2]; vp = c[3]; pv = c[4]; ve = c[5]; prior = c[6];
            cp = c[8:7]; io = c[10:9];
            exp_if = prior; exp_vif = 1'b0; exp_f = 2'b00;
            ecpl = v ? 2'd3 : cp;
            ext = (!v && cp == 2'd3 && pv) || (v && ve);
            if (lk)             begin exp_f = 2'b10; tag = "R6"; end
            else if (!p)        begin exp_if = 1'b1; tag = "R2"; end
            else if (io >= ecpl) begin exp_if = 1'b1; tag = "R3"; end
            else if (ext && !vp) begin exp_vif = 1'b1; tag = "R4"; end
            else                begin exp_f = 2'b01; tag = "R5"; end
            shad = (exp_f == 2'b00) && !prior && exp_if;

            do_reset();
            if (prior) begin
                set_mode(0, 0, 0, 0, 0, 0, 0, 0);
                do_retire(2'b01);
                do_retire(2'b00);
            end
            set_mode(p, v, cp, io, vp, pv, ve, lk);
            do_retire(2'b01);
            chk({tag, " fault"}, last_fault, exp_f);
            chk({tag, " if"}, if_o, exp_if);
            chk({tag, " vif"}, vif_o, exp_vif);
            chk(shad ? "R8 ack in shadow" : (prior && exp_if ? "R9 ack" : "R11 ack"),
                iack, exp_if && !shad);
            chk("R12 nmi", nack, !shad);
            set_mode(0, 0, 0, 0, 0, 0, 0, 0);
            do_retire(2'b00);
            chk("R11 ack after release", iack, exp_if);
            chk("R13 other opcode keeps if", if_o, exp_if);
        end

        // Disable instruction sweep, with VIF already set
        for (int c = 0; c < 64; c++) begin
            logic lk, p, v;
            logic [1:0] cp, io;
            lk = c[0]; p = c[1]; v = c[2]; cp = c[4:3]; io = c[5] ? 2'd3 : 2'd0;
            do_reset();
            set_mode(0, 0, 0, 0, 0, 0, 0, 0);
            do_retire(2'b01);
            do_retire(2'b00);
            set_mode(1, 1, 3, 0, 0, 0, 1, 0);
            do_retire(2'b01);
            set_mode(p, v, cp, io, 0, 0, 0, lk);
            do_retire(2'b10);
            chk(lk ? "R6 clr fault" : "R7 clr fault", last_fault, lk ? 2 : 0);
            chk(lk ? "R6 clr if" : "R7 clr if", if_o, lk ? 1 : 0);
            chk("R7 vif kept", vif_o, 1);
        end

        // R10: disable right after enable
        do_reset();
        set_mode(0, 0, 0, 0, 0, 0, 0, 0);
        do_retire(2'b01);
        chk("R10 ack after enable", iack, 0);
        do_retire(2'b10);
        chk("R10 ack after disable", iack, 0);
        do_retire(2'b00);
        chk("R10 ack later", iack, 0);

        // R9: back-to-back enables
        do_reset();
        do_retire(2'b01);
        chk("R9 first enable shadow", iack, 0);
        do_retire(2'b01);
        chk("R9 second enable no shadow", iack, 1);

        // R12: fault reported inside shadow, nmi held then released
        do_reset();
        do_retire(2'b01);
        chk("R12 nmi held", nack, 0);
        lock = 1'b1;
        do_retire(2'b01);
        chk("R12 fault in shadow", last_fault, 2);
        chk("R12 nmi released", nack, 1);
        lock = 1'b0;
        nreq = 1'b0;
        #1 chk("R12 no nmi request", nack, 0);
        ireq = 1'b0;
        #1 chk("R11 no request", iack, 0);

        // R13: no retirement -> no fault, no flag change
        do_reset();
        @(negedge clk);
        op = 2'b01; retire = 1'b0;
        #1 chk("R13 fault idle", fault, 0);
        @(negedge clk);
        #1 chk("R13 if idle", if_o, 0);
        op = 2'b00;

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule